// File: doc/BRIEF.md
# TDM Serial Input Frame Receiver

This block receives one serial input stream from a time-division-multiplexed highway and turns it into 16-bit words for a processor core. The bit clock, data line and frame sync arrive asynchronously. They are resynchronised to the system clock, and each falling edge of the bit clock is detected as a single-cycle sample strike. No logic is clocked by the bit clock itself.

Before it is used, the frame sync passes through a conditioning stage. That stage can invert its level and can delay it by one bit period. A word is assembled most significant bit first and then placed in a one-entry holding register, which acts as the second half of a double buffer. The block raises a level interrupt while that register is full and a one-cycle interrupt pulse on each framing error.

There are two modes. In packet mode, each sync starts exactly one word and later bits are ignored until the next sync. In frame mode, a sync starts a frame of `SLOTS` back-to-back words, and the next frame must start with another sync.

Top module: `tdm_rx`

## Requirements
- R1: After reset, `word_full_o`, `overrun_o` and `ferr_o` are 0 and `word_o` is 0.
- R2: The bit at the start of a word and the 15 bits after it are assembled MSB first: the first bit goes to bit 15 and the 16th to bit 0. After the 16th falling edge the word appears on `word_o` and `word_full_o` goes to 1.
- R3: Bits whose falling edges arrive before the first internal sync after reset are ignored, and no word is produced.
- R4: In packet mode (`frame_mode_i`=0), once a word is complete, further bits without a sync are ignored.
- R5: With `sync_inv_i`=1, the internal sync is the inverse of `fsync_i`: a low pin marks the start bit.
- R6: With `sync_dly_i`=1, the internal sync seen at a falling edge is the conditioned level from the previous falling edge, so the word starts one bit later.
- R7: In frame mode (`frame_mode_i`=1), one sync yields `SLOTS` (default 4) consecutive words with no frame error.
- R8: In frame mode, if no sync is present on the bit after `SLOTS`*16 bits of a frame, a frame error is raised and that bit starts a new frame.
- R9: A sync arriving while a word is partly assembled raises a frame error, drops the partial bits, and starts a new word with that bit.
- R10: A word that completes while the holding register is full overwrites it and sets `overrun_o`, which stays set until a read.
- R11: A `rd_i` pulse clears `word_full_o` and `overrun_o`.
- R12: Each frame error produces `ferr_o` high for exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock; data sampled at its falling edge |
| sdata_i | input | 1 | Serial data |
| fsync_i | input | 1 | Frame sync pin, before conditioning |
| sync_inv_i | input | 1 | 1: invert frame sync level |
| sync_dly_i | input | 1 | 1: delay frame sync by one bit |
| frame_mode_i | input | 1 | 0: packet mode, 1: frame mode |
| rd_i | input | 1 | Core read strobe for the holding register |
| word_o | output | 16 | Holding register contents |
| word_full_o | output | 1 | Buffer-full interrupt |
| ferr_o | output | 1 | Frame-error interrupt pulse |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench sends walking-one and walking-zero words through packet mode, so a design that swaps bit order or loses a bit position returns a wrong value. It also sends bits before the first sync and after a completed packet; a design that does not gate these produces a word where none is expected. Two cases check the sync conditioning: with delay on, a leading dummy bit that is 1 would corrupt the word if the delay were missing, and with inversion on, an idle-high pin marks no starts. The frame tests cover a full four-word frame, a missing fifth sync, a truncated word and back-to-back unread words, and a design that counts errors wrongly or keeps the overrun flag set after a read is caught by the error-pulse counter or the flag checks.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned SLOTS_DEF  = 4;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic inv;
    logic dly;
    logic frame;
  } rx_cfg_t;
endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tdm_rx_fscond.sv
module tdm_rx_fscond (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_edge_i,
  input  logic fs_raw_i,
  input  logic inv_i,
  input  logic dly_i,
  output logic fs_o
);
  logic fs_lvl;
  logic fs_q, fs_n;

  assign fs_lvl = fs_raw_i ^ inv_i;

  always_comb begin
    fs_n = fs_q;
    if (bit_edge_i) fs_n = fs_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= fs_n;
  end

  assign fs_o = dly_i ? fs_q : fs_lvl;
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SLOTS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_edge_i,
  input  logic              din_i,
  input  logic              fs_i,
  input  logic              frame_mode_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] word_o,
  output logic              err_o
);
  localparam int unsigned FRAME_BITS = WORD_W * SLOTS;
  localparam int unsigned BCNT_W = $clog2(WORD_W);
  localparam int unsigned FCNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(WORD_W - 1);
  localparam logic [FCNT_W-1:0] FRAME_END = FCNT_W'(FRAME_BITS);

  logic [WORD_W-2:0] sh_q, sh_n;
  logic [BCNT_W-1:0] bcnt_q, bcnt_n;
  logic [FCNT_W-1:0] fcnt_q, fcnt_n;
  logic              act_q, act_n;
  logic              vld_q, vld_n;
  logic              err_q, err_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic              start, shift;

  always_comb begin
    sh_n   = sh_q;
    bcnt_n = bcnt_q;
    fcnt_n = fcnt_q;
    act_n  = act_q;
    word_n = word_q;
    vld_n  = 1'b0;
    err_n  = 1'b0;
    start  = 1'b0;
    shift  = 1'b0;
    if (bit_edge_i) begin
      if (fs_i) begin
        start = 1'b1;
        err_n = act_q && (bcnt_q != '0);
      end else if (act_q && frame_mode_i && (fcnt_q == FRAME_END)) begin
        start = 1'b1;
        err_n = 1'b1;
      end else if (act_q) begin
        shift = 1'b1;
      end
    end
    if (start) begin
      sh_n   = {sh_q[WORD_W-3:0], din_i};
      bcnt_n = BCNT_W'(1);
      fcnt_n = FCNT_W'(1);
      act_n  = 1'b1;
    end else if (shift) begin
      sh_n = {sh_q[WORD_W-3:0], din_i};
      if (frame_mode_i) fcnt_n = fcnt_q + 1'b1;
      if (bcnt_q == LAST_BIT) begin
        vld_n  = 1'b1;
        word_n = {sh_q, din_i};
        bcnt_n = '0;
        if (!frame_mode_i) act_n = 1'b0;
      end else begin
        bcnt_n = bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bcnt_q <= '0;
      fcnt_q <= '0;
      act_q  <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      word_q <= '0;
    end else begin
      sh_q   <= sh_n;
      bcnt_q <= bcnt_n;
      fcnt_q <= fcnt_n;
      act_q  <= act_n;
      vld_q  <= vld_n;
      err_q  <= err_n;
      word_q <= word_n;
    end
  end

  assign vld_o  = vld_q;
  assign word_o = word_q;
  assign err_o  = err_q;
endmodule

// File: rtl/tdm_rx_hold.sv
module tdm_rx_hold #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o
);
  logic [WORD_W-1:0] data_q, data_n;
  logic              full_q, full_n;
  logic              ovr_q, ovr_n;

  always_comb begin
    data_n = data_q;
    full_n = full_q;
    ovr_n  = ovr_q;
    if (push_i) begin
      data_n = word_i;
      full_n = 1'b1;
      if (full_q && !rd_i) ovr_n = 1'b1;
      else if (rd_i)       ovr_n = 1'b0;
    end else if (rd_i) begin
      full_n = 1'b0;
      ovr_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      full_q <= full_n;
      ovr_q  <= ovr_n;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = WORD_W_DEF,
  parameter int unsigned SLOTS       = SLOTS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              sdata_i,
  input  logic              fsync_i,
  input  logic              sync_inv_i,
  input  logic              sync_dly_i,
  input  logic              frame_mode_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_full_o,
  output logic              ferr_o,
  output logic              overrun_o
);
  logic        rst_meta_q, rst_int_n;
  rx_cfg_t     cfg;
  logic [2:0]  pins_s;
  logic        bclk_s, din_s, fs_s;
  logic        bclk_prev_q;
  logic        bit_edge;
  logic        fs_int;
  logic        word_vld;
  logic [WORD_W-1:0] word_asm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  assign cfg = '{inv: sync_inv_i, dly: sync_dly_i, frame: frame_mode_i};

  tdm_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({bclk_i, sdata_i, fsync_i}),
    .q_o   (pins_s)
  );
  assign {bclk_s, din_s, fs_s} = pins_s;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) bclk_prev_q <= 1'b0;
    else            bclk_prev_q <= bclk_s;
  end
  assign bit_edge = bclk_prev_q & ~bclk_s;

  tdm_rx_fscond u_fscond (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bit_edge_i (bit_edge),
    .fs_raw_i   (fs_s),
    .inv_i      (cfg.inv),
    .dly_i      (cfg.dly),
    .fs_o       (fs_int)
  );

  tdm_rx_deser #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_deser (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .bit_edge_i   (bit_edge),
    .din_i        (din_s),
    .fs_i         (fs_int),
    .frame_mode_i (cfg.frame),
    .vld_o        (word_vld),
    .word_o       (word_asm),
    .err_o        (ferr_o)
  );

  tdm_rx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .push_i (word_vld),
    .word_i (word_asm),
    .rd_i   (rd_i),
    .data_o (word_o),
    .full_o (word_full_o),
    .ovr_o  (overrun_o)
  );
endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_i,
  input logic full_i,
  input logic ovr_i,
  input logic ferr_i,
  input logic push_i,
  input logic edge_i
);
  // R12
  ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_i |=> !ferr_i);

  // R9
  ferr_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_i |-> $past(edge_i));

  // R11
  rd_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_i && rd_i && !push_i) |=> (!full_i && !ovr_i));

  // R10
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_i) |-> ($past(full_i) && $past(push_i)));

  // R2
  full_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_i) |-> $past(push_i));

  // R10
  push_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> full_i);
endmodule

bind tdm_rx tdm_rx_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_i   (rd_i),
  .full_i (word_full_o),
  .ovr_i  (overrun_o),
  .ferr_i (ferr_o),
  .push_i (word_vld),
  .edge_i (bit_edge)
);

// File: tb/tdm_rx_tb.sv
module tdm_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int W = 16;
  localparam int SLOTS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, sdata = 1'b0, fsync = 1'b0;
  logic inv = 1'b0, dly = 1'b0, fmode = 1'b0, rd = 1'b0;
  logic [W-1:0] word;
  logic full, ferr, ovr;
  int checks = 0, errors = 0, ferr_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .sdata_i(sdata), .fsync_i(fsync),
    .sync_inv_i(inv), .sync_dly_i(dly), .frame_mode_i(fmode), .rd_i(rd),
    .word_o(word), .word_full_o(full), .ferr_o(ferr), .overrun_o(ovr)
  );

  always @(posedge clk) if (rst_n && ferr) ferr_cnt++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic i, logic d, logic f);
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0; sdata = 1'b0; rd = 1'b0;
    inv = i; dly = d; fmode = f; fsync = i;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ferr_cnt = 0;
  endtask

  task automatic send_bit(logic fs, logic d);
    bclk = 1'b1; sdata = d; fsync = fs ^ inv;
    repeat (HALF) @(negedge clk);
    bclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_word(logic [W-1:0] w, logic sync);
    for (int i = W-1; i >= 0; i--) send_bit(sync && (i == W-1), w[i]);
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    int e0;
    do_reset(1'b0, 1'b0, 1'b0);
    // R1 reset state
    check("R1 full", full, 0);
    check("R1 ovr", ovr, 0);
    check("R1 ferr", ferr, 0);
    check("R1 word", word, 0);

    // R3 bits before any sync
    for (int i = 0; i < 20; i++) send_bit(1'b0, 1'b1);
    check("R3 no word", full, 0);

    // R2 walking one / walking zero sweep, packet mode
    for (int i = 0; i < 2*W; i++) begin
      v = (i < W) ? (W'(1) << i) : ~(W'(1) << (i - W));
      send_word(v, 1'b1);
      check("R2 word", word, v);
      check("R2 full", full, 1);
      do_read();
      check("R11 full cleared", full, 0);
    end

    // R4 trailing bits ignored in packet mode
    send_word(16'hBEEF, 1'b1);
    do_read();
    send_word(16'h1234, 1'b0);
    check("R4 no word", full, 0);
    check("R4 word kept", word, 16'hBEEF);
    check("R4 no ferr", ferr_cnt, 0);

    // R10 overrun, R11 read clears it
    send_word(16'hA5C3, 1'b1);
    send_word(16'h3C5A, 1'b1);
    check("R10 word", word, 16'h3C5A);
    check("R10 ovr", ovr, 1);
    check("R10 full", full, 1);
    do_read();
    check("R11 full", full, 0);
    check("R11 ovr", ovr, 0);

    // R9 early sync inside a word, R12 single pulse
    e0 = ferr_cnt;
    for (int i = 0; i < 5; i++) send_bit(i == 0, 1'b1);
    send_word(16'h0F0F, 1'b1);
    check("R9 word", word, 16'h0F0F);
    check("R12 one pulse", ferr_cnt - e0, 1);
    do_read();

    // R5 inverted sync
    do_reset(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b1);
    check("R5 idle high ignored", full, 0);
    send_word(16'hC001, 1'b1);
    check("R5 word", word, 16'hC001);
    check("R5 full", full, 1);

    // R6 delayed sync
    do_reset(1'b0, 1'b1, 1'b0);
    send_bit(1'b1, 1'b1);
    send_word(16'h5A01, 1'b0);
    check("R6 word", word, 16'h5A01);
    check("R6 full", full, 1);

    // R7 frame mode, R8 missing sync
    do_reset(1'b0, 1'b0, 1'b1);
    for (int s = 0; s < SLOTS; s++) begin
      v = W'(16'h1111 * (s + 1));
      send_word(v, s == 0);
      check("R7 slot word", word, v);
      do_read();
    end
    check("R7 no ferr", ferr_cnt, 0);
    send_word(16'h7E81, 1'b0);
    check("R8 ferr", ferr_cnt, 1);
    check("R8 word", word, 16'h7E81);
    do_read();
    send_word(16'h2468, 1'b1);
    check("R8 boundary sync ok", ferr_cnt, 1);
    check("R8 next word", word, 16'h2468);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule